// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit collects five single-cycle event pulses from a serial link controller: transmit complete, receive complete, transmit FIFO underrun, receive FIFO overflow and serial gap seen. It holds them in a sticky status byte and masks that byte with an enable byte. From the masked result it drives one level-sensitive interrupt line. A transmit-complete pulse counts only when the slot that just finished asked for a completion notice.

Software reaches the unit through a plain byte port: an address, a write strobe, write data and combinational read data.
- The status byte is write-one-to-clear.
- The enable byte is written directly.
- In both bytes the three low bits always read as ones.
- A third, read-only byte reports live receiver state taken from input flags.
- Addresses that map to none of these bytes read as zero.

Top module: `irq_unit`

## Requirements
- R1: After synchronous reset, every status and enable source bit is 0, both bytes read 0x07, and `irqOut` is 0.
- R2: An event pulse sets its status bit, which stays set until it is cleared. The status byte has this layout: bit 7 transmit done, bit 6 receive done, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap.
- R3: `evTxDone` sets bit 7 only when `txReqDone` is 1 in the same cycle. When `txReqDone` is 0 the pulse has no effect.
- R4: A write to the status offset (0x0C) clears each status bit whose write-data bit is 1. Bits written 0 are left unchanged, and a write never sets a bit.
- R5: A write to the enable offset (0x0D) loads bits 7..3 from the write data. Bits 2..0 of the written value are ignored.
- R6: When an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R7: `irqOut` is the OR over bits 7..3 of status AND enable, delayed by one register. It rises one cycle after a bit is latched, and falls one cycle after the bit is cleared.
- R8: The receiver status byte at offset 0x0F reads as follows: bit 4 receiver busy, bit 2 high-rate receive active, bit 1 mid-rate receive active, bit 0 low-rate receive active. Bits 7..5 and bit 3 read as 0. Writes to this offset change nothing.
- R9: Any other offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Byte offset for read and write |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data at `addr` |
| evTxDone | input | 1 | Transmit slot completed (pulse) |
| txReqDone | input | 1 | The completed slot requested a done event |
| evRxDone | input | 1 | Receive completed (pulse) |
| evTxUnderrun | input | 1 | Transmit FIFO underrun (pulse) |
| evRxOverflow | input | 1 | Receive FIFO overflow (pulse) |
| evSerialGap | input | 1 | Serial gap received (pulse) |
| rxBusy | input | 1 | Receiver busy flag |
| rxHighRate | input | 1 | High-rate receive active |
| rxMidRate | input | 1 | Mid-rate receive active |
| rxLowRate | input | 1 | Low-rate receive active |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default parameters: a 5-bit offset space with the status, enable and receiver status bytes at 0x0C, 0x0D and 0x0F. With these values all three mapped bytes can be reached, and so can unmapped offsets such as 0x05 and 0x1F. Every event source is pulsed in turn, and the bench also:
- gates the transmit-done pulse with its request flag;
- places a clear in the same cycle as an event;
- times the interrupt edge against the latch edge, both with the source enabled and with it masked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_CNT = 5;
  localparam int PAD_CNT = 3;
  localparam int REG_W   = SRC_CNT + PAD_CNT;

  // source index inside the SRC_CNT-wide vectors (byte bit = index + PAD_CNT)
  localparam int SRC_GAP     = 0;
  localparam int SRC_RXOVER  = 1;
  localparam int SRC_TXUNDER = 2;
  localparam int SRC_RXDONE  = 3;
  localparam int SRC_TXDONE  = 4;

  typedef struct packed {
    logic [SRC_CNT-1:0] statusClr;
    logic               enableWr;
    logic [SRC_CNT-1:0] enableVal;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int STATUS_OFS  = 'h0C,
  parameter int ENABLE_OFS  = 'h0D,
  parameter int RXSTAT_OFS  = 'h0F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [SRC_CNT-1:0] statusBits,
  input  logic [SRC_CNT-1:0] enableBits,
  input  logic               rxBusy,
  input  logic               rxHighRate,
  input  logic               rxMidRate,
  input  logic               rxLowRate,
  output ctlStrobes_t        strobes,
  output logic [REG_W-1:0]   rdData
);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_OFS);
  localparam logic [ADDR_W-1:0] RXSTAT_A = ADDR_W'(RXSTAT_OFS);
  localparam logic [PAD_CNT-1:0] PAD_ONES = '1;

  logic hitStatus, hitEnable, hitRxStat;
  logic unusedWrLow;

  assign hitStatus = (addr == STATUS_A);
  assign hitEnable = (addr == ENABLE_A);
  assign hitRxStat = (addr == RXSTAT_A);
  assign unusedWrLow = ^wrData[PAD_CNT-1:0];

  always_comb begin
    strobes.statusClr = '0;
    strobes.enableWr  = 1'b0;
    strobes.enableVal = wrData[REG_W-1:PAD_CNT];
    if (wrEn && hitStatus) strobes.statusClr = wrData[REG_W-1:PAD_CNT];
    if (wrEn && hitEnable) strobes.enableWr  = 1'b1;
  end

  always_comb begin
    rdData = '0;
    if (hitStatus)      rdData = {statusBits, PAD_ONES};
    else if (hitEnable) rdData = {enableBits, PAD_ONES};
    else if (hitRxStat) rdData = {3'b000, rxBusy, 1'b0, rxHighRate, rxMidRate, rxLowRate};
  end

  // both strobe kinds can never be active together
  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    !(strobes.enableWr && (|strobes.statusClr)));

  assert_low_ones_R1: assert property (@(posedge clk) disable iff (rst)
    (hitStatus || hitEnable) |-> (rdData[PAD_CNT-1:0] == PAD_ONES));

  assert_rxstat_zero_R8: assert property (@(posedge clk) disable iff (rst)
    hitRxStat |-> (rdData[7:5] == 3'b000 && rdData[3] == 1'b0));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    !(hitStatus || hitEnable || hitRxStat) |-> (rdData == '0));
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [SRC_CNT-1:0] evVec,
  input  ctlStrobes_t        strobes,
  output logic [SRC_CNT-1:0] statusBits,
  output logic [SRC_CNT-1:0] enableBits,
  output logic               irqOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      statusBits <= '0;
      enableBits <= '0;
      irqOut     <= 1'b0;
    end else begin
      statusBits <= (statusBits & ~strobes.statusClr) | evVec;
      if (strobes.enableWr) enableBits <= strobes.enableVal;
      irqOut <= |(statusBits & enableBits);
    end
  end

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    |evVec |=> ((statusBits & $past(evVec)) == $past(evVec)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    |strobes.statusClr |=> ((statusBits & $past(strobes.statusClr & ~evVec)) == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (strobes.statusClr == '0) |=> ((statusBits & $past(statusBits)) == $past(statusBits)));

  assert_irq_low_R7: assert property (@(posedge clk) disable iff (rst)
    ((statusBits & enableBits) == '0) |=> !irqOut);

  assert_irq_high_R7: assert property (@(posedge clk) disable iff (rst)
    ((statusBits & enableBits) != '0) |=> irqOut);
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int STATUS_OFS = 'h0C,
  parameter int ENABLE_OFS = 'h0D,
  parameter int RXSTAT_OFS = 'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              evTxDone,
  input  logic              txReqDone,
  input  logic              evRxDone,
  input  logic              evTxUnderrun,
  input  logic              evRxOverflow,
  input  logic              evSerialGap,
  input  logic              rxBusy,
  input  logic              rxHighRate,
  input  logic              rxMidRate,
  input  logic              rxLowRate,
  output logic              irqOut
);
  ctlStrobes_t        strobes;
  logic [SRC_CNT-1:0] evVec, statusBits, enableBits;

  always_comb begin
    evVec = '0;
    evVec[SRC_TXDONE]  = evTxDone & txReqDone;
    evVec[SRC_RXDONE]  = evRxDone;
    evVec[SRC_TXUNDER] = evTxUnderrun;
    evVec[SRC_RXOVER]  = evRxOverflow;
    evVec[SRC_GAP]     = evSerialGap;
  end

  irq_control #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS),
    .ENABLE_OFS(ENABLE_OFS), .RXSTAT_OFS(RXSTAT_OFS)
  ) ctl_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .statusBits(statusBits), .enableBits(enableBits),
    .rxBusy(rxBusy), .rxHighRate(rxHighRate), .rxMidRate(rxMidRate),
    .rxLowRate(rxLowRate), .strobes(strobes), .rdData(rdData)
  );

  irq_datapath dp_i (
    .clk(clk), .rst(rst), .evVec(evVec), .strobes(strobes),
    .statusBits(statusBits), .enableBits(enableBits), .irqOut(irqOut)
  );

  // a transmit-done pulse without its request flag leaves bit 7 clear
  assert_txdone_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (!statusBits[SRC_TXDONE] && !(evTxDone && txReqDone)) |=> !statusBits[SRC_TXDONE]);
endmodule

// File: tb/irq_unit_tb.sv
module irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic evTxDone = 0, txReqDone = 0, evRxDone = 0, evTxUnderrun = 0;
  logic evRxOverflow = 0, evSerialGap = 0;
  logic rxBusy = 0, rxHighRate = 0, rxMidRate = 0, rxLowRate = 0;
  logic irqOut;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_unit dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  // drives one event pulse (bit index in byte layout 7..3)
  task automatic pulse(input int b, input logic req);
    @(negedge clk);
    case (b)
      7: begin evTxDone = 1; txReqDone = req; end
      6: evRxDone = 1;
      5: evTxUnderrun = 1;
      4: evRxOverflow = 1;
      default: evSerialGap = 1;
    endcase
    @(negedge clk);
    evTxDone = 0; txReqDone = 0; evRxDone = 0; evTxUnderrun = 0;
    evRxOverflow = 0; evSerialGap = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(5'h0C, d); check("R1 status after reset", d, 8'h07);
    rd(5'h0D, d); check("R1 enable after reset", d, 8'h07);
    check("R1 irq after reset", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic t_each_event();
    logic [7:0] d;
    for (int b = 3; b <= 6; b++) begin
      pulse(b, 1'b0);
      rd(5'h0C, d); check("R2 event latched", d, 8'h07 | (8'h1 << b));
      @(negedge clk); rd(5'h0C, d); check("R2 event sticky", d, 8'h07 | (8'h1 << b));
      wr(5'h0C, 8'hF8);
      rd(5'h0C, d); check("R4 full clear", d, 8'h07);
    end
  endtask

  task automatic t_txdone_gate();
    logic [7:0] d;
    pulse(7, 1'b0);
    rd(5'h0C, d); check("R3 tx done without request ignored", d, 8'h07);
    pulse(7, 1'b1);
    rd(5'h0C, d); check("R3 tx done with request", d, 8'h87);
    wr(5'h0C, 8'h80);
  endtask

  task automatic t_partial_clear();
    logic [7:0] d;
    pulse(6, 1'b0); pulse(3, 1'b0);
    rd(5'h0C, d); check("R2 two sources", d, 8'h4F);
    wr(5'h0C, 8'h47);
    rd(5'h0C, d); check("R4 partial clear keeps gap", d, 8'h0F);
    wr(5'h0C, 8'h30);
    rd(5'h0C, d); check("R4 write of ones never sets", d, 8'h0F);
    wr(5'h0C, 8'h08);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(5'h0D, 8'hFF); rd(5'h0D, d); check("R5 enable all", d, 8'hFF);
    wr(5'h0D, 8'hA0); rd(5'h0D, d); check("R5 enable pattern low bits ignored", d, 8'hA7);
    wr(5'h0D, 8'h00); rd(5'h0D, d); check("R5 enable cleared", d, 8'h07);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse(4, 1'b0);
    @(negedge clk); addr = 5'h0C; wrData = 8'h18; wrEn = 1; evRxOverflow = 1;
    @(negedge clk); wrEn = 0; evRxOverflow = 0;
    rd(5'h0C, d); check("R6 event beats clear", d, 8'h17);
    wr(5'h0C, 8'h10);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(5'h0D, 8'h40);
    pulse(6, 1'b0);
    check("R7 irq not yet high", {7'd0, irqOut}, 8'h00);
    @(negedge clk);
    check("R7 irq high one cycle later", {7'd0, irqOut}, 8'h01);
    wr(5'h0C, 8'h40);
    check("R7 irq still high in clear cycle", {7'd0, irqOut}, 8'h01);
    @(negedge clk);
    check("R7 irq falls after clear", {7'd0, irqOut}, 8'h00);
    pulse(3, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R7 masked source no irq", {7'd0, irqOut}, 8'h00);
    rd(5'h0C, d); check("R7 masked source still latched", d, 8'h0F);
    wr(5'h0C, 8'hF8); wr(5'h0D, 8'h00);
  endtask

  task automatic t_rxstat();
    logic [7:0] d;
    @(negedge clk); rxBusy = 1; rxHighRate = 0; rxMidRate = 1; rxLowRate = 0;
    rd(5'h0F, d); check("R8 receiver status pattern A", d, 8'h12);
    rxBusy = 0; rxHighRate = 1; rxMidRate = 0; rxLowRate = 1;
    rd(5'h0F, d); check("R8 receiver status pattern B", d, 8'h05);
    wr(5'h0F, 8'hFF);
    rd(5'h0F, d); check("R8 write ignored", d, 8'h05);
    rd(5'h0C, d); check("R8 write to 0x0F leaves status", d, 8'h07);
    rd(5'h0D, d); check("R8 write to 0x0F leaves enable", d, 8'h07);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(5'h05, d); check("R9 unmapped 0x05", d, 8'h00);
    rd(5'h1F, d); check("R9 unmapped 0x1F", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_each_event();
    t_txdone_gate();
    t_partial_clear();
    t_enable();
    t_collision();
    t_irq();
    t_rxstat();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule